// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block holds the four-state coherence status (Modified, Exclusive, Shared, Invalid) for a small, indexed set of lines in one private cache that sits on a shared snooping bus. Processor reads and writes are checked against the stored status. A hit is answered in one cycle. A miss or a write that needs ownership becomes a bus request: read (code 1), read-exclusive (code 2) or upgrade (code 3). The request is held until the arbiter grants it, and the line is installed once the snoop responses are complete.

It also watches transactions that other agents put on the bus. For each snoop it returns one registered response: whether it held a valid copy, whether it drives the block onto the bus for a cache-to-cache transfer, and whether memory must capture that block because it was dirty. One configuration input marks this cache as the sharer that supplies data for clean shared lines. The data array, the memory side and bus arbitration are outside the block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid, `cpu_ready` is high and every response and request output is low.
- R2: A read on an Invalid line issues a read request (code 1). When `bus_resp_done` arrives the line becomes Shared if `bus_resp_shared` is high and Exclusive if it is low. `cpu_resp_valid` (with hit low) never rises before `bus_resp_done`.
- R3: A write on an Invalid line issues read-exclusive (code 2) and ends in Modified. `cpu_resp_from_peer` copies `bus_resp_peer` at completion.
- R4: A write on a Shared line issues upgrade (code 3) and ends in Modified with `cpu_resp_from_peer` low. A write on an Exclusive line is a hit with no bus request, and the line becomes Modified.
- R5: Reads on Shared, Exclusive or Modified lines and writes on Modified lines answer `cpu_resp_valid` with `cpu_resp_hit` high one cycle later and raise no bus request.
- R6: On an Exclusive line, a snooped read moves it to Shared and a snooped read-exclusive moves it to Invalid. Both assert `snp_shared` and `snp_flush` with `snp_wb` low.
- R7: On a Modified line, a snooped read moves it to Shared and a snooped read-exclusive moves it to Invalid. Both assert `snp_shared`, `snp_flush` and `snp_wb`.
- R8: On a Shared line, a snooped read-exclusive or upgrade moves it to Invalid. An upgrade never asserts `snp_flush`. A read-exclusive asserts `snp_flush` only when `cfg_sharer_supply` is high.
- R9: Any snoop on an Invalid line leaves the line Invalid and asserts no snoop response output.
- R10: A snooped read on a Shared line keeps it Shared, asserts `snp_shared`, and asserts `snp_flush` only when `cfg_sharer_supply` is high.
- R11: A pending bus request holds `bus_req_valid`, its command and its index while `bus_grant` is low. The line state does not change and `cpu_ready` stays low.
- R12: A snooped read-exclusive or upgrade on the line of a pending, ungranted upgrade changes `bus_req_cmd` to read-exclusive on the next cycle.
- R13: When a snoop and a processor request reach the same line in the same cycle, the snoop transition is applied first and the processor request is judged on the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sharer_supply | input | 1 | This cache supplies data for clean Shared lines |
| cpu_req_valid | input | 1 | Processor request, taken when `cpu_ready` is high |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_idx | input | IDX_W | Line index of the processor request |
| cpu_ready | output | 1 | No request outstanding |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_hit | output | 1 | Completion was a hit |
| cpu_resp_from_peer | output | 1 | Fill data came from a peer cache |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 1 read, 2 read-exclusive, 3 upgrade |
| bus_req_idx | output | IDX_W | Line index of the bus request |
| bus_grant | input | 1 | Arbiter grants the pending request |
| bus_resp_done | input | 1 | All snoop responses for the granted request collected |
| bus_resp_shared | input | 1 | Another cache reported a valid copy |
| bus_resp_peer | input | 1 | Data was supplied by a peer cache |
| snp_valid | input | 1 | Snooped transaction from another agent |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_req_cmd` |
| snp_idx | input | IDX_W | Snooped line index |
| snp_shared | output | 1 | Held a valid copy when snooped |
| snp_flush | output | 1 | Drives the block onto the bus |
| snp_wb | output | 1 | Supplied block is dirty; memory must capture it |

## Verification
A snoop and a processor request can hit the same line in the same cycle. The bench provokes this by raising `snp_valid` and `cpu_req_valid` on one falling edge for the same index. With a Modified line and a snooped read paired with a processor write, it expects a dirty supply together with an upgrade request. With a snooped read-exclusive paired with a processor read, it expects a dirty supply together with a read miss. A second overlap, a snooped invalidation arriving while this cache's own upgrade waits for a grant, is judged by the command that is later granted and by where the fill data comes from.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_UPGR = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WGNT = 2'd1,
    PH_WRSP = 2'd2
  } phase_t;

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_a_idx,
  output line_st_t         rd_a_st,
  input  logic [IDX_W-1:0] rd_b_idx,
  output line_st_t         rd_b_st,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  line_st_t         wa_st,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  line_st_t         wb_st
);

  line_st_t st_q [NUM_LINES];

  // Port b (processor side) wins when both ports write one line; its value
  // is already computed from the snoop result.
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g] <= ST_I;
      end else if (wb_en && wb_idx == IDX_W'(g)) begin
        st_q[g] <= wb_st;
      end else if (wa_en && wa_idx == IDX_W'(g)) begin
        st_q[g] <= wa_st;
      end
    end
  end

  assign rd_a_st = st_q[rd_a_idx];
  assign rd_b_st = st_q[rd_b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     snp_valid,
  input  bus_cmd_t snp_cmd,
  input  line_st_t cur_st,
  input  logic     cfg_sharer_supply,
  output line_st_t nxt_st,
  output logic     st_we,
  output logic     snp_shared,
  output logic     snp_flush,
  output logic     snp_wb
);

  logic sh_d, fl_d, wb_d;

  always_comb begin
    nxt_st = cur_st;
    sh_d   = 1'b0;
    fl_d   = 1'b0;
    wb_d   = 1'b0;
    if (snp_valid) begin
      unique case (cur_st)
        ST_S: begin
          unique case (snp_cmd)
            BC_RD: begin
              sh_d = 1'b1;
              fl_d = cfg_sharer_supply;
            end
            BC_RDX: begin
              sh_d   = 1'b1;
              fl_d   = cfg_sharer_supply;
              nxt_st = ST_I;
            end
            BC_UPGR: nxt_st = ST_I;
            default: ;
          endcase
        end
        ST_E: begin
          unique case (snp_cmd)
            BC_RD: begin
              sh_d   = 1'b1;
              fl_d   = 1'b1;
              nxt_st = ST_S;
            end
            BC_RDX: begin
              sh_d   = 1'b1;
              fl_d   = 1'b1;
              nxt_st = ST_I;
            end
            default: ;
          endcase
        end
        ST_M: begin
          unique case (snp_cmd)
            BC_RD: begin
              sh_d   = 1'b1;
              fl_d   = 1'b1;
              wb_d   = 1'b1;
              nxt_st = ST_S;
            end
            BC_RDX: begin
              sh_d   = 1'b1;
              fl_d   = 1'b1;
              wb_d   = 1'b1;
              nxt_st = ST_I;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign st_we = snp_valid && (nxt_st != cur_st);

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_shared <= 1'b0;
      snp_flush  <= 1'b0;
      snp_wb     <= 1'b0;
    end else begin
      snp_shared <= sh_d;
      snp_flush  <= fl_d;
      snp_wb     <= wb_d;
    end
  end

  a_r8_upgr_no_data: assert property (@(posedge clk) disable iff (rst)
    snp_valid && snp_cmd == BC_UPGR |=> !snp_flush && !snp_wb);

  a_r9_invalid_silent: assert property (@(posedge clk) disable iff (rst)
    snp_valid && cur_st == ST_I |=> !snp_shared && !snp_flush && !snp_wb);

endmodule

// File: rtl/mesi_cpu_unit.sv
module mesi_cpu_unit
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_req_valid,
  input  logic             cpu_req_write,
  input  logic [IDX_W-1:0] cpu_req_idx,
  input  line_st_t         cur_st,
  input  logic             snp_valid,
  input  bus_cmd_t         snp_cmd,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             bus_grant,
  input  logic             bus_resp_done,
  input  logic             bus_resp_shared,
  input  logic             bus_resp_peer,
  output logic             cpu_ready,
  output logic             cpu_resp_valid,
  output logic             cpu_resp_hit,
  output logic             cpu_resp_from_peer,
  output logic             bus_req_valid,
  output bus_cmd_t         bus_req_cmd,
  output logic [IDX_W-1:0] bus_req_idx,
  output logic             st_we,
  output logic [IDX_W-1:0] st_idx,
  output line_st_t         st_val
);

  phase_t ph_q;
  logic   accept, is_hit, conv;

  assign cpu_ready = (ph_q == PH_IDLE);
  assign accept    = cpu_ready && cpu_req_valid;
  assign is_hit    = cpu_req_write ? (cur_st == ST_M || cur_st == ST_E)
                                   : (cur_st != ST_I);
  // Lost the shared copy while waiting: the upgrade must fetch data.
  assign conv = (ph_q == PH_WGNT) && (bus_req_cmd == BC_UPGR) && snp_valid &&
                (snp_idx == bus_req_idx) &&
                (snp_cmd == BC_RDX || snp_cmd == BC_UPGR);

  always_comb begin
    st_we  = 1'b0;
    st_idx = cpu_req_idx;
    st_val = ST_M;
    if (accept && cpu_req_write && cur_st == ST_E) begin
      st_we = 1'b1;
    end else if (ph_q == PH_WRSP && bus_resp_done) begin
      st_we  = 1'b1;
      st_idx = bus_req_idx;
      if (bus_req_cmd == BC_RD) st_val = bus_resp_shared ? ST_S : ST_E;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q               <= PH_IDLE;
      cpu_resp_valid     <= 1'b0;
      cpu_resp_hit       <= 1'b0;
      cpu_resp_from_peer <= 1'b0;
      bus_req_valid      <= 1'b0;
      bus_req_cmd        <= BC_NONE;
      bus_req_idx        <= '0;
    end else begin
      cpu_resp_valid <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            if (is_hit) begin
              cpu_resp_valid     <= 1'b1;
              cpu_resp_hit       <= 1'b1;
              cpu_resp_from_peer <= 1'b0;
            end else begin
              bus_req_valid <= 1'b1;
              bus_req_idx   <= cpu_req_idx;
              if (!cpu_req_write)      bus_req_cmd <= BC_RD;
              else if (cur_st == ST_S) bus_req_cmd <= BC_UPGR;
              else                     bus_req_cmd <= BC_RDX;
              ph_q <= PH_WGNT;
            end
          end
        end
        PH_WGNT: begin
          if (conv) bus_req_cmd <= BC_RDX;
          if (bus_grant) begin
            bus_req_valid <= 1'b0;
            ph_q          <= PH_WRSP;
          end
        end
        PH_WRSP: begin
          if (bus_resp_done) begin
            cpu_resp_valid     <= 1'b1;
            cpu_resp_hit       <= 1'b0;
            cpu_resp_from_peer <= (bus_req_cmd == BC_UPGR) ? 1'b0 : bus_resp_peer;
            ph_q               <= PH_IDLE;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  a_r2_wait_for_done: assert property (@(posedge clk) disable iff (rst)
    ph_q == PH_WRSP && !bus_resp_done |=> !cpu_resp_valid);

  a_r4_silent_upgrade: assert property (@(posedge clk) disable iff (rst)
    accept && cpu_req_write && cur_st == ST_E |=>
      cpu_resp_valid && cpu_resp_hit && !bus_req_valid);

  a_r11_hold_until_grant: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid && !bus_grant |=> bus_req_valid && $stable(bus_req_idx) && !cpu_ready);

  a_r12_upgrade_to_rdx: assert property (@(posedge clk) disable iff (rst)
    conv |=> bus_req_cmd == BC_RDX);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter  int NUM_LINES = 8,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_sharer_supply,
  input  logic             cpu_req_valid,
  input  logic             cpu_req_write,
  input  logic [IDX_W-1:0] cpu_req_idx,
  output logic             cpu_ready,
  output logic             cpu_resp_valid,
  output logic             cpu_resp_hit,
  output logic             cpu_resp_from_peer,
  output logic             bus_req_valid,
  output logic [1:0]       bus_req_cmd,
  output logic [IDX_W-1:0] bus_req_idx,
  input  logic             bus_grant,
  input  logic             bus_resp_done,
  input  logic             bus_resp_shared,
  input  logic             bus_resp_peer,
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             snp_shared,
  output logic             snp_flush,
  output logic             snp_wb
);

  line_st_t snp_cur, snp_nxt, cpu_raw, cpu_eff, cpu_wval;
  logic     snp_we, cpu_we;
  logic [IDX_W-1:0] cpu_widx;
  bus_cmd_t snp_cmd_t, req_cmd_t;

  assign snp_cmd_t   = bus_cmd_t'(snp_cmd);
  assign bus_req_cmd = req_cmd_t;

  mesi_state_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_array (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (snp_idx),
    .rd_a_st  (snp_cur),
    .rd_b_idx (cpu_req_idx),
    .rd_b_st  (cpu_raw),
    .wa_en    (snp_we),
    .wa_idx   (snp_idx),
    .wa_st    (snp_nxt),
    .wb_en    (cpu_we),
    .wb_idx   (cpu_widx),
    .wb_st    (cpu_wval)
  );

  mesi_snoop_unit #(.IDX_W(IDX_W)) u_snoop (
    .clk               (clk),
    .rst               (rst),
    .snp_valid         (snp_valid),
    .snp_cmd           (snp_cmd_t),
    .cur_st            (snp_cur),
    .cfg_sharer_supply (cfg_sharer_supply),
    .nxt_st            (snp_nxt),
    .st_we             (snp_we),
    .snp_shared        (snp_shared),
    .snp_flush         (snp_flush),
    .snp_wb            (snp_wb)
  );

  // Same-cycle ordering: the processor sees the post-snoop state.
  assign cpu_eff = (snp_valid && snp_idx == cpu_req_idx) ? snp_nxt : cpu_raw;

  mesi_cpu_unit #(.IDX_W(IDX_W)) u_cpu (
    .clk                (clk),
    .rst                (rst),
    .cpu_req_valid      (cpu_req_valid),
    .cpu_req_write      (cpu_req_write),
    .cpu_req_idx        (cpu_req_idx),
    .cur_st             (cpu_eff),
    .snp_valid          (snp_valid),
    .snp_cmd            (snp_cmd_t),
    .snp_idx            (snp_idx),
    .bus_grant          (bus_grant),
    .bus_resp_done      (bus_resp_done),
    .bus_resp_shared    (bus_resp_shared),
    .bus_resp_peer      (bus_resp_peer),
    .cpu_ready          (cpu_ready),
    .cpu_resp_valid     (cpu_resp_valid),
    .cpu_resp_hit       (cpu_resp_hit),
    .cpu_resp_from_peer (cpu_resp_from_peer),
    .bus_req_valid      (bus_req_valid),
    .bus_req_cmd        (req_cmd_t),
    .bus_req_idx        (bus_req_idx),
    .st_we              (cpu_we),
    .st_idx             (cpu_widx),
    .st_val             (cpu_wval)
  );

  a_r7_dirty_means_supply: assert property (@(posedge clk) disable iff (rst)
    snp_wb |-> snp_flush && snp_shared);

endmodule

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [1:0] cpu_req_idx = '0;
  logic cpu_ready, cpu_resp_valid, cpu_resp_hit, cpu_resp_from_peer;
  logic bus_req_valid;
  logic [1:0] bus_req_cmd, bus_req_idx;
  logic bus_grant = 1'b0, bus_resp_done = 1'b0, bus_resp_shared = 1'b0, bus_resp_peer = 1'b0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0, snp_idx = '0;
  logic snp_shared, snp_flush, snp_wb;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_line_ctrl #(.NUM_LINES(NL)) uut (
    .clk(clk), .rst(rst), .cfg_sharer_supply(cfg),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write), .cpu_req_idx(cpu_req_idx),
    .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid), .cpu_resp_hit(cpu_resp_hit),
    .cpu_resp_from_peer(cpu_resp_from_peer),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_idx(bus_req_idx),
    .bus_grant(bus_grant), .bus_resp_done(bus_resp_done), .bus_resp_shared(bus_resp_shared),
    .bus_resp_peer(bus_resp_peer),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
    .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_wb(snp_wb)
  );

  typedef struct packed {
    logic       snp;   // 1 = snoop vector, 0 = processor vector
    logic       wr;
    logic [1:0] idx;
    logic [1:0] cmd;   // snoop command
    logic       rsh;   // bus_resp_shared given on completion
    logic       rpeer; // bus_resp_peer given on completion
    logic       cfg;
    logic       ehit;
    logic [1:0] ecmd;  // expected bus command, 0 = hit
    logic       epeer;
    logic       esh;
    logic       efl;
    logic       ewb;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0, 1'b0,2'd1,1'b0, 1'b0,1'b0,1'b0, 4'd2 }, // R2 read miss, fill E
    '{1'b0,1'b1,2'd0,2'd0,1'b0,1'b0,1'b0, 1'b1,2'd0,1'b0, 1'b0,1'b0,1'b0, 4'd4 }, // R4 silent E->M
    '{1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0, 1'b1,2'd0,1'b0, 1'b0,1'b0,1'b0, 4'd5 }, // R5 read hit M
    '{1'b1,1'b0,2'd0,2'd1,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0, 1'b1,1'b1,1'b1, 4'd7 }, // R7 M rd -> S
    '{1'b0,1'b1,2'd0,2'd0,1'b0,1'b0,1'b0, 1'b0,2'd3,1'b0, 1'b0,1'b0,1'b0, 4'd4 }, // R4 S write upgrade
    '{1'b1,1'b0,2'd0,2'd2,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0, 1'b1,1'b1,1'b1, 4'd7 }, // R7 M rdx -> I
    '{1'b0,1'b0,2'd0,2'd0,1'b1,1'b1,1'b0, 1'b0,2'd1,1'b1, 1'b0,1'b0,1'b0, 4'd2 }, // R2 fill S from peer
    '{1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0, 1'b1,2'd0,1'b0, 1'b0,1'b0,1'b0, 4'd5 }, // R5 read hit S
    '{1'b1,1'b0,2'd0,2'd1,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0, 1'b1,1'b0,1'b0, 4'd10}, // R10 no supply
    '{1'b1,1'b0,2'd0,2'd1,1'b0,1'b0,1'b1, 1'b0,2'd0,1'b0, 1'b1,1'b1,1'b0, 4'd10}, // R10 designated supply
    '{1'b1,1'b0,2'd0,2'd3,1'b0,1'b0,1'b1, 1'b0,2'd0,1'b0, 1'b0,1'b0,1'b0, 4'd8 }, // R8 upgrade on S
    '{1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0, 1'b0,2'd1,1'b0, 1'b0,1'b0,1'b0, 4'd8 }, // R8 line now I, fill E
    '{1'b1,1'b0,2'd0,2'd2,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0, 1'b1,1'b1,1'b0, 4'd6 }, // R6 E rdx -> I
    '{1'b0,1'b1,2'd1,2'd0,1'b0,1'b1,1'b0, 1'b0,2'd2,1'b1, 1'b0,1'b0,1'b0, 4'd3 }, // R3 write miss, peer
    '{1'b0,1'b1,2'd1,2'd0,1'b0,1'b0,1'b0, 1'b1,2'd0,1'b0, 1'b0,1'b0,1'b0, 4'd5 }, // R5 write hit M
    '{1'b1,1'b0,2'd2,2'd1,1'b0,1'b0,1'b1, 1'b0,2'd0,1'b0, 1'b0,1'b0,1'b0, 4'd9 }, // R9 rd on I
    '{1'b1,1'b0,2'd2,2'd2,1'b0,1'b0,1'b1, 1'b0,2'd0,1'b0, 1'b0,1'b0,1'b0, 4'd9 }, // R9 rdx on I
    '{1'b0,1'b0,2'd2,2'd0,1'b0,1'b0,1'b0, 1'b0,2'd1,1'b0, 1'b0,1'b0,1'b0, 4'd9 }, // R9 still I, fill E
    '{1'b1,1'b0,2'd2,2'd1,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0, 1'b1,1'b1,1'b0, 4'd6 }, // R6 E rd -> S
    '{1'b0,1'b0,2'd3,2'd0,1'b1,1'b0,1'b0, 1'b0,2'd1,1'b0, 1'b0,1'b0,1'b0, 4'd2 }, // R2 fill S from memory
    '{1'b1,1'b0,2'd3,2'd2,1'b0,1'b0,1'b1, 1'b0,2'd0,1'b0, 1'b1,1'b1,1'b0, 4'd8 }, // R8 S rdx supply
    '{1'b0,1'b1,2'd3,2'd0,1'b0,1'b0,1'b0, 1'b0,2'd2,1'b0, 1'b0,1'b0,1'b0, 4'd3 }  // R3 write miss, memory
  };

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Grant, then completion; checks the processor response.
  task automatic finish_bus(input string tag, input logic rsh, input logic rpeer,
                            input logic epeer);
    bus_grant = 1'b1;
    step();
    bus_grant = 1'b0;
    check({tag, " req dropped after grant"}, bus_req_valid, 0);
    bus_resp_done = 1'b1; bus_resp_shared = rsh; bus_resp_peer = rpeer;
    step();
    bus_resp_done = 1'b0; bus_resp_shared = 1'b0; bus_resp_peer = 1'b0;
    check({tag, " resp valid"}, cpu_resp_valid, 1);
    check({tag, " resp hit"}, cpu_resp_hit, 0);
    check({tag, " from peer"}, cpu_resp_from_peer, epeer);
  endtask

  task automatic do_snoop(input string tag, input logic [1:0] c, input logic [1:0] i,
                          input logic cf, input logic esh, input logic efl, input logic ewb);
    snp_valid = 1'b1; snp_cmd = c; snp_idx = i; cfg = cf;
    step();
    snp_valid = 1'b0; cfg = 1'b0;
    check({tag, " snp_shared"}, snp_shared, esh);
    check({tag, " snp_flush"}, snp_flush, efl);
    check({tag, " snp_wb"}, snp_wb, ewb);
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    if (v.snp) begin
      do_snoop(tag, v.cmd, v.idx, v.cfg, v.esh, v.efl, v.ewb);
    end else begin
      cpu_req_valid = 1'b1; cpu_req_write = v.wr; cpu_req_idx = v.idx;
      step();
      cpu_req_valid = 1'b0;
      if (v.ecmd == 2'd0) begin
        check({tag, " hit resp"}, cpu_resp_valid, 1);
        check({tag, " hit flag"}, cpu_resp_hit, v.ehit);
        check({tag, " no bus req"}, bus_req_valid, 0);
      end else begin
        check({tag, " bus req"}, bus_req_valid, 1);
        check({tag, " bus cmd"}, bus_req_cmd, v.ecmd);
        check({tag, " bus idx"}, bus_req_idx, v.idx);
        finish_bus(tag, v.rsh, v.rpeer, v.epeer);
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    check("R1 ready", cpu_ready, 1);
    check("R1 resp", cpu_resp_valid, 0);
    check("R1 bus req", bus_req_valid, 0);
    check("R1 snoop outs", {snp_shared, snp_flush, snp_wb}, 0);
    do_snoop("R1 line 1 invalid", 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // State now: line0 I, line1 M, line2 S, line3 M.

    // R11: request waits for grant; no state change meanwhile.
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_idx = 2'd0;
    step();
    cpu_req_valid = 1'b0;
    check("R11 req raised", bus_req_valid, 1);
    for (int k = 0; k < 4; k++) begin
      step();
      check("R11 held", bus_req_valid, 1);
      check("R11 ready low", cpu_ready, 0);
      check("R11 cmd held", bus_req_cmd, 1);
      check("R11 no resp", cpu_resp_valid, 0);
    end
    do_snoop("R11 line unchanged", 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    bus_grant = 1'b1;
    step();
    bus_grant = 1'b0;
    step();
    step();
    check("R2 no resp before done", cpu_resp_valid, 0);
    bus_resp_done = 1'b1;
    step();
    bus_resp_done = 1'b0;
    check("R2 resp after done", cpu_resp_valid, 1);
    do_snoop("R2 filled E", 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);

    // R12: pending upgrade on line2 (S) is invalidated before grant.
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_idx = 2'd2;
    step();
    cpu_req_valid = 1'b0;
    check("R12 upgrade issued", bus_req_cmd, 3);
    do_snoop("R12 snoop upgrade", 2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R12 converted", bus_req_cmd, 2);
    check("R12 still pending", bus_req_valid, 1);
    finish_bus("R12", 1'b0, 1'b1, 1'b1);
    do_snoop("R12 line M", 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1);

    // R13: same-cycle snoop read + processor write on line1 (M).
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_idx = 2'd1;
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_idx = 2'd1;
    step();
    cpu_req_valid = 1'b0; snp_valid = 1'b0;
    check("R13 dirty supply", {snp_shared, snp_flush, snp_wb}, 7);
    check("R13 upgrade after snoop", bus_req_cmd, 3);
    check("R13 no hit", cpu_resp_valid, 0);
    finish_bus("R13 upgrade", 1'b0, 1'b0, 1'b0);
    // R13: same-cycle snoop rdx + processor read on line1 (M).
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_idx = 2'd1;
    snp_valid = 1'b1; snp_cmd = 2'd2; snp_idx = 2'd1;
    step();
    cpu_req_valid = 1'b0; snp_valid = 1'b0;
    check("R13 rdx supply", {snp_shared, snp_flush, snp_wb}, 7);
    check("R13 read miss", bus_req_cmd, 1);
    check("R13 miss pending", bus_req_valid, 1);
    finish_bus("R13 read", 1'b0, 1'b0, 1'b0);
    do_snoop("R13 line E", 2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule